// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This clocked controller turns the two system sleep requests (an active-low suspend-to-RAM request and an enable whose low level means soft-off) into on/off commands for a memory-supply switcher, a termination LDO, an auxiliary LDO and an always-on LDO. It also drives the control levels for the two power switches that feed the dual 5 V rail, a soft-start charge and discharge command, and a power-good flag. Comparator results from the analog side arrive as level flags: bias supply above its lockout, main 5 V present, soft-start done and above its top level, switcher output discharged, feedback inside its window, each LDO in regulation, and the protection latch set.

Power-up has a fixed order. While the bias supply is low, the controller sits in reset and discharges soft-start. Once the supply is good, it ignores every request for a programmable number of cycles. After that it waits for main 5 V. It then lets a settle interval run and waits until the switcher output is discharged. Only then does it start the switcher. The two linear regulators are enabled only after soft-start reports that the switcher is up. Every level input passes through a two-flop synchronizer first.

Top module: `acpi_pwr_seq`

## Requirements
- R1: While `vccOk` is low, all regulator enables, `blkRel`, `sbyOff`, `ssChg` and `pGood` are 0 and `ssDis` is 1.
- R2: After `vccOk` rises, the request inputs are ignored for `IGN_CYC` cycles. During this window `alwEn` and `ssDis` are 1 and `swEn` is 0, even when every start condition is already met.
- R3: With `sysEn` low (soft-off), only `alwEn` is on among the enables, `blkRel` is 0, `sbyOff` is 1, `ssDis` is 1 and `pGood` is 0.
- R4: `swEn` stays 0 while `main5vOk` is low.
- R5: After `main5vOk` is seen, `swEn` rises only once `SETTLE_CYC` cycles have passed and `outLow` is 1.
- R6: During switcher soft-start, `swEn`, `alwEn` and `ssChg` are 1 and `ttEn` and `auxEn` are 0. The two linear regulators turn on only after `ssDone`.
- R7: In suspend (`sysEn` high, `s3ReqN` low, switcher up), `swEn` and `alwEn` are 1. `ttEn`, `auxEn`, `blkRel`, `sbyOff`, `ssChg`, `ssDis` and `pGood` are all 0.
- R8: In the working state (both requests high, switcher up, main 5 V good), `swEn`, `ttEn`, `auxEn`, `blkRel`, `sbyOff` and `ssChg` are 1, and `alwEn` and `ssDis` are 0.
- R9: A rising `s3ReqN` while in suspend does not leave suspend until `main5vOk` is 1.
- R10: `pGood` is 1 only in the working state while `s3ReqN`, `ssTop`, `fbInWin`, `ttInReg` and `auxInReg` are all 1 and `faultSet` is 0. Any one of them failing drives it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vccOk | input | 1 | Bias supply above its lockout level |
| sysEn | input | 1 | High = not soft-off |
| s3ReqN | input | 1 | Low = suspend-to-RAM request |
| main5vOk | input | 1 | Main 5 V rail above its threshold |
| ssDone | input | 1 | Soft-start complete (switcher OK) |
| ssTop | input | 1 | Soft-start above its top level |
| outLow | input | 1 | Switcher output below the residual limit |
| fbInWin | input | 1 | Switcher feedback inside its window |
| ttInReg | input | 1 | Termination LDO in regulation |
| auxInReg | input | 1 | Auxiliary LDO in regulation |
| faultSet | input | 1 | Protection latch is set |
| swEn | output | 1 | Switcher enable |
| ttEn | output | 1 | Termination LDO enable |
| auxEn | output | 1 | Auxiliary LDO enable |
| alwEn | output | 1 | Always-on LDO enable |
| blkRel | output | 1 | Blocking switch released (high) |
| sbyOff | output | 1 | Standby switch turned off (high) |
| ssChg | output | 1 | Soft-start charge command |
| ssDis | output | 1 | Soft-start discharge command |
| pGood | output | 1 | Power-good flag |

## Verification
The properties assume that each input flag is a level that stays put for more than two clock cycles. Each one compares a rising enable with the synchronized flags one cycle earlier, so a glitch shorter than the synchronizer would fall outside what they describe. The directed stimulus only changes inputs on falling clock edges and holds every level for at least three cycles before it samples. It also keeps the analog flags consistent with the state being tested: `outLow` is held high while the switcher runs, and `ssDone` is high before any test that enters the working state.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_UVLO, ST_IGN, ST_S5, ST_WMAIN, ST_SETTLE, ST_SOFT, ST_S3, ST_S0
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntRun;
    logic pgArm;
  } seqStrobe_t;

  typedef struct packed {
    logic ignDone;
    logic setDone;
  } seqTimer_t;

  typedef struct packed {
    logic sw;
    logic tt;
    logic aux;
    logic alw;
    logic blk;
    logic sby;
    logic ssChg;
    logic ssDis;
  } seqDrive_t;

  localparam int NUM_FLAGS = 11;
  localparam int F_VCC  = 0;
  localparam int F_EN   = 1;
  localparam int F_S3N  = 2;
  localparam int F_MAIN = 3;
  localparam int F_DONE = 4;
  localparam int F_TOP  = 5;
  localparam int F_LOW  = 6;
  localparam int F_FB   = 7;
  localparam int F_TT   = 8;
  localparam int F_AUX  = 9;
  localparam int F_FLT  = 10;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta;
    logic stab;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta <= 1'b0;
        stab <= 1'b0;
      end else begin
        meta <= dIn[i];
        stab <= meta;
      end
    end
    assign dOut[i] = stab;
  end
endmodule

// File: rtl/seq_dp.sv
module seq_dp
  import seq_pkg::*;
#(
  parameter int IGN_CYC    = 2000,
  parameter int SETTLE_CYC = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       s3S,
  input  logic       topS,
  input  logic       fbS,
  input  logic       ttS,
  input  logic       auxS,
  input  logic       fltS,
  output seqTimer_t  timer,
  output logic       pGood
);
  localparam int MAXC = (IGN_CYC > SETTLE_CYC) ? IGN_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] IGN_LAST = CW'(IGN_CYC - 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(MAXC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            cnt <= '0;
    else if (strobe.cntClr)               cnt <= '0;
    else if (strobe.cntRun && cnt != CNT_TOP) cnt <= cnt + 1'b1;
  end

  assign timer.ignDone = (cnt >= IGN_LAST);
  assign timer.setDone = (cnt >= SET_LAST);

  assign pGood = strobe.pgArm & s3S & topS & ~fltS & fbS & ttS & auxS;

  p_cnt_bounded_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> (cnt == '0));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vccS,
  input  logic       enS,
  input  logic       s3S,
  input  logic       mainS,
  input  logic       doneS,
  input  logic       lowS,
  input  seqTimer_t  timer,
  output seqStrobe_t strobe,
  output seqDrive_t  drv
);
  seqState_t st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_UVLO;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    if (!vccS) begin
      nxt = ST_UVLO;
    end else if (st != ST_UVLO && st != ST_IGN && !enS) begin
      nxt = ST_S5;
    end else begin
      case (st)
        ST_UVLO:   nxt = ST_IGN;
        ST_IGN:    if (timer.ignDone) nxt = enS ? ST_WMAIN : ST_S5;
        ST_S5:     nxt = ST_WMAIN;
        ST_WMAIN:  if (mainS) nxt = ST_SETTLE;
        ST_SETTLE: begin
          if (!mainS)                        nxt = ST_WMAIN;
          else if (timer.setDone && lowS)    nxt = ST_SOFT;
        end
        ST_SOFT:   if (doneS) nxt = (s3S && mainS) ? ST_S0 : ST_S3;
        ST_S3:     if (s3S && mainS) nxt = ST_S0;
        ST_S0:     if (!s3S) nxt = ST_S3;
        default:   nxt = ST_UVLO;
      endcase
    end
  end

  always_comb begin
    strobe.cntClr = (nxt != st);
    strobe.cntRun = (nxt == st);
    strobe.pgArm  = (st == ST_S0);
  end

  always_comb begin
    drv = '0;
    case (st)
      ST_UVLO:   drv.ssDis = 1'b1;
      ST_IGN, ST_WMAIN, ST_SETTLE: begin
        drv.alw   = 1'b1;
        drv.ssDis = 1'b1;
      end
      ST_S5: begin
        drv.alw   = 1'b1;
        drv.sby   = 1'b1;
        drv.ssDis = 1'b1;
      end
      ST_SOFT: begin
        drv.sw    = 1'b1;
        drv.alw   = 1'b1;
        drv.ssChg = 1'b1;
      end
      ST_S3: begin
        drv.sw  = 1'b1;
        drv.alw = 1'b1;
      end
      ST_S0: begin
        drv.sw    = 1'b1;
        drv.tt    = 1'b1;
        drv.aux   = 1'b1;
        drv.blk   = 1'b1;
        drv.sby   = 1'b1;
        drv.ssChg = 1'b1;
      end
      default: drv.ssDis = 1'b1;
    endcase
  end

  p_uvlo_safe_r1: assert property (@(posedge clk) disable iff (!rstN)
    !vccS |=> (!drv.sw && !drv.tt && drv.ssDis));
  p_soft_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (vccS && !enS) |=> (!drv.sw && !drv.tt && !drv.blk));
  p_sw_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drv.sw) |-> $past(timer.setDone && lowS && mainS));
  p_ldo_after_sw_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drv.tt) |-> $past(drv.sw));
  p_wake_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drv.tt) |-> $past(s3S && mainS));
endmodule

// File: rtl/acpi_pwr_seq.sv
module acpi_pwr_seq
  import seq_pkg::*;
#(
  parameter int IGN_CYC    = 2000,
  parameter int SETTLE_CYC = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic vccOk,
  input  logic sysEn,
  input  logic s3ReqN,
  input  logic main5vOk,
  input  logic ssDone,
  input  logic ssTop,
  input  logic outLow,
  input  logic fbInWin,
  input  logic ttInReg,
  input  logic auxInReg,
  input  logic faultSet,
  output logic swEn,
  output logic ttEn,
  output logic auxEn,
  output logic alwEn,
  output logic blkRel,
  output logic sbyOff,
  output logic ssChg,
  output logic ssDis,
  output logic pGood
);
  logic [NUM_FLAGS-1:0] rawFlags, syncFlags;
  seqStrobe_t strobe;
  seqTimer_t  timer;
  seqDrive_t  drv;

  always_comb begin
    rawFlags         = '0;
    rawFlags[F_VCC]  = vccOk;
    rawFlags[F_EN]   = sysEn;
    rawFlags[F_S3N]  = s3ReqN;
    rawFlags[F_MAIN] = main5vOk;
    rawFlags[F_DONE] = ssDone;
    rawFlags[F_TOP]  = ssTop;
    rawFlags[F_LOW]  = outLow;
    rawFlags[F_FB]   = fbInWin;
    rawFlags[F_TT]   = ttInReg;
    rawFlags[F_AUX]  = auxInReg;
    rawFlags[F_FLT]  = faultSet;
  end

  seq_sync #(.WIDTH(NUM_FLAGS)) u_sync (
    .clk(clk), .rstN(rstN), .dIn(rawFlags), .dOut(syncFlags)
  );

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .vccS(syncFlags[F_VCC]), .enS(syncFlags[F_EN]), .s3S(syncFlags[F_S3N]),
    .mainS(syncFlags[F_MAIN]), .doneS(syncFlags[F_DONE]), .lowS(syncFlags[F_LOW]),
    .timer(timer), .strobe(strobe), .drv(drv)
  );

  seq_dp #(.IGN_CYC(IGN_CYC), .SETTLE_CYC(SETTLE_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .s3S(syncFlags[F_S3N]), .topS(syncFlags[F_TOP]), .fbS(syncFlags[F_FB]),
    .ttS(syncFlags[F_TT]), .auxS(syncFlags[F_AUX]), .fltS(syncFlags[F_FLT]),
    .timer(timer), .pGood(pGood)
  );

  assign swEn   = drv.sw;
  assign ttEn   = drv.tt;
  assign auxEn  = drv.aux;
  assign alwEn  = drv.alw;
  assign blkRel = drv.blk;
  assign sbyOff = drv.sby;
  assign ssChg  = drv.ssChg;
  assign ssDis  = drv.ssDis;

  p_pg_working_r10: assert property (@(posedge clk) disable iff (!rstN)
    pGood |-> (swEn && ttEn && auxEn && blkRel && !alwEn));
endmodule

// File: tb/acpi_pwr_seq_tb.sv
module acpi_pwr_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vccOk = 0, sysEn = 0, s3ReqN = 1, main5vOk = 0, ssDone = 0, ssTop = 0;
  logic outLow = 0, fbInWin = 0, ttInReg = 0, auxInReg = 0, faultSet = 0;
  logic swEn, ttEn, auxEn, alwEn, blkRel, sbyOff, ssChg, ssDis, pGood;
  int nRun = 0, nFail = 0;
  bit finished = 0;

  // output vector order: sw tt aux alw blk sby chg dis pg
  localparam logic [8:0] V_UVLO = 9'b000000010;
  localparam logic [8:0] V_WAIT = 9'b000100010;
  localparam logic [8:0] V_S5   = 9'b000101010;
  localparam logic [8:0] V_SOFT = 9'b100100100;
  localparam logic [8:0] V_S3   = 9'b100100000;
  localparam logic [8:0] V_S0   = 9'b111011100;
  localparam logic [8:0] V_S0PG = 9'b111011101;

  always #10 clk = ~clk;

  acpi_pwr_seq #(.IGN_CYC(20), .SETTLE_CYC(16)) u_dut (
    .clk(clk), .rstN(rstN), .vccOk(vccOk), .sysEn(sysEn), .s3ReqN(s3ReqN),
    .main5vOk(main5vOk), .ssDone(ssDone), .ssTop(ssTop), .outLow(outLow),
    .fbInWin(fbInWin), .ttInReg(ttInReg), .auxInReg(auxInReg), .faultSet(faultSet),
    .swEn(swEn), .ttEn(ttEn), .auxEn(auxEn), .alwEn(alwEn), .blkRel(blkRel),
    .sbyOff(sbyOff), .ssChg(ssChg), .ssDis(ssDis), .pGood(pGood)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [8:0] exp);
    logic [8:0] got;
    got = {swEn, ttEn, auxEn, alwEn, blkRel, sbyOff, ssChg, ssDis, pGood};
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic tReset();
    tick(3); rstN = 1'b1; tick(2);
    chk("R1 reset/uvlo", V_UVLO);
  endtask

  task automatic tIgnoreWindow();
    sysEn = 1; main5vOk = 1; outLow = 1; s3ReqN = 1; vccOk = 1;
    tick(10); chk("R2 inside ignore window", V_WAIT);
    tick(20); chk("R5 settle still running", V_WAIT);
    tick(20); chk("R6 soft-start phase", V_SOFT);
  endtask

  task automatic tSoftToS0();
    tick(20); chk("R6 ldos held until ssDone", V_SOFT);
    ssDone = 1; tick(5); chk("R8 working state", V_S0);
  endtask

  task automatic tPowerGood();
    ssTop = 1; fbInWin = 1; ttInReg = 1; auxInReg = 1; faultSet = 0;
    tick(5); chk("R10 all conditions met", V_S0PG);
    for (int k = 0; k < 5; k++) begin
      case (k)
        0: ssTop = 0; 1: fbInWin = 0; 2: ttInReg = 0; 3: auxInReg = 0;
        default: faultSet = 1;
      endcase
      tick(5); chk($sformatf("R10 condition %0d missing", k), V_S0);
      ssTop = 1; fbInWin = 1; ttInReg = 1; auxInReg = 1; faultSet = 0;
      tick(5); chk($sformatf("R10 condition %0d restored", k), V_S0PG);
    end
  endtask

  task automatic tSuspend();
    s3ReqN = 0; tick(5); chk("R7 suspend outputs, pGood forced low", V_S3);
  endtask

  task automatic tWakeHoldoff();
    main5vOk = 0; tick(4); s3ReqN = 1; tick(30);
    chk("R9 wake held without main 5V", V_S3);
    main5vOk = 1; tick(5); chk("R9 wake after main 5V", V_S0PG);
  endtask

  task automatic tSoftOff();
    sysEn = 0; tick(5); chk("R3 soft-off outputs", V_S5);
  endtask

  task automatic tMainGate();
    ssDone = 0; main5vOk = 0; outLow = 0; sysEn = 1;
    tick(60); chk("R4 no switcher without main 5V", V_WAIT);
    main5vOk = 1; tick(10); chk("R5 settle interval running", V_WAIT);
    tick(30); chk("R5 waiting for discharged output", V_WAIT);
    outLow = 1; tick(5); chk("R6 soft-start after discharge", V_SOFT);
    ssDone = 1; tick(5); chk("R8 working state again", V_S0PG);
  endtask

  task automatic tUvlo();
    vccOk = 0; tick(5); chk("R1 supply lockout", V_UVLO);
  endtask

  initial begin
    tReset();
    tIgnoreWindow();
    tSoftToS0();
    tPowerGood();
    tSuspend();
    tWakeHoldoff();
    tSoftOff();
    tMainGate();
    tUvlo();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule